// File: doc/BRIEF.md
# Label-Filtered Receive Word Queue

This block sits between a serial word receiver and a host processor. Each 32-bit word that the receiver delivers is offered for one cycle on the word input. The block either writes the word into a receive FIFO or discards it. Two things decide which: a compare-enable control bit, and a label table that the host loads one entry at a time. The table is indexed by the word's 8-bit label field. Each entry holds an accept mask with one bit for each of the four values of the 2-bit source/destination field.

The host can invalidate the whole table in a single cycle. When it does, the old masks stay in storage but no longer match. Only entries written after that point take part in filtering.

The host sees the queue through a first-word-fall-through read port. It also sees an 8-bit status value carrying the empty, threshold-reached, full and sticky overflow flags, and an interrupt that is the OR of the three fill flags.

Top module: `lblf_rx_top`

## Requirements
- R1: While the compare-enable bit (control bit 0) is clear, every offered word is written into the FIFO when the FIFO is not full, and words leave in arrival order.
- R2: While compare-enable is set, a word is written only if two conditions hold. Its label (word bits 7:0) must have a table entry written since the last invalidation. The mask bit of that entry selected by the word's source/destination field (word bits 9:8) must be 1.
- R3: A word that passes the filter while the FIFO is full is dropped, the FIFO contents stay unchanged, and status bit 3 (overflow) becomes 1 on the next cycle.
- R4: The overflow bit stays set until a status read strobe. The value shown during the strobe cycle still carries it, and it reads 0 afterwards unless a new drop occurs in that same cycle.
- R5: A control write with bit 7 set invalidates every table entry in one cycle. Masks written earlier stop matching. Entries written afterwards match. Bit 0 of that same write becomes the new compare-enable.
- R6: Status bit 0 is 1 when the FIFO holds no word. Bit 1 is 1 when the count is at least the programmed threshold (reset value DEPTH/2). Bit 2 is 1 when the count equals DEPTH. Bits 7:4 read 0.
- R7: The interrupt output equals the OR of status bits 0, 1 and 2.
- R8: A read strobe on an empty FIFO has no effect on the pointers, and the read data port shows zero whenever the FIFO is empty.
- R9: When not empty, the read data port shows the oldest stored word, and a read strobe advances to the next one.
- R10: After reset the FIFO is empty, overflow is clear, compare-enable is clear and every table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Received word present this cycle |
| word_data | input | 32 | Received word |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control value: bit 0 compare-enable, bit 7 invalidate table |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | CW | FIFO level threshold |
| lbl_we | input | 1 | Label table write strobe |
| lbl_idx | input | 8 | Label table index |
| lbl_mask | input | 4 | Source/destination accept mask for that label |
| fifo_re | input | 1 | FIFO read strobe |
| fifo_rdata | output | 32 | Oldest stored word, zero when empty |
| stat_re | input | 1 | Status read strobe, clears overflow |
| stat_out | output | 8 | Status: bit 0 empty, 1 level, 2 full, 3 overflow |
| irq | output | 1 | Interrupt, high while any fill flag is high |

## Verification
A corrupted valid vector or mask entry shows up as a wrong accept or reject decision. The bench catches it at the empty flag and the read data one cycle after the offered word, and it sweeps all 256 labels with all four source/destination codes. A wrong pointer or count shows up at the next read as a misordered or missing word. It also shows at once as a wrong flag pattern, because the bench checks the status after every push and pop while the FIFO fills to full and drains to empty. A lost overflow bit is visible at the first status sample after the drop.

// File: rtl/lblf_pkg.sv
package lblf_pkg;
  localparam int LBL_W  = 8;
  localparam int SDI_W  = 2;
  localparam int WORD_W = 32;
  localparam int NLBL   = 1 << LBL_W;
  localparam int NSDI   = 1 << SDI_W;

  localparam int CTRL_CMP_BIT    = 0;
  localparam int CTRL_REINIT_BIT = 7;

  localparam int ST_EMPTY = 0;
  localparam int ST_LEVEL = 1;
  localparam int ST_FULL  = 2;
  localparam int ST_OVF   = 3;

  typedef logic [LBL_W-1:0] label_t;
  typedef logic [SDI_W-1:0] sdi_t;
  typedef logic [NSDI-1:0]  sdi_mask_t;

  // Table hit: entry valid and the mask selects this source/destination code.
  function automatic logic entry_hit(input logic valid, input sdi_mask_t mask, input sdi_t sdi);
    return valid && mask[sdi];
  endfunction

  // Word admission rule.
  function automatic logic admit(input logic cmp_en, input logic hit);
    return !cmp_en || hit;
  endfunction
endpackage

// File: rtl/lblf_label_table.sv
module lblf_label_table
  import lblf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reinit,
  input  logic      wr_en,
  input  label_t    wr_label,
  input  sdi_mask_t wr_mask,
  input  label_t    rd_label,
  input  sdi_t      rd_sdi,
  output logic      hit
);
  logic [NLBL-1:0] valid_q, valid_d;
  sdi_mask_t       mask_mem [NLBL];

  // Invalidation clears the valid vector; a same-cycle write lands after it.
  always_comb begin
    valid_d = reinit ? '0 : valid_q;
    if (wr_en) valid_d[wr_label] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // Mask storage is never cleared; stale masks are hidden by the valid vector.
  always_ff @(posedge clk) begin
    if (wr_en) mask_mem[wr_label] <= wr_mask;
  end

  assign hit = entry_hit(valid_q[rd_label], mask_mem[rd_label], rd_sdi);
endmodule

// File: rtl/lblf_fifo.sv
module lblf_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/lblf_status.sv
module lblf_status
  import lblf_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          empty,
  input  logic          full,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] thr,
  input  logic          drop,
  input  logic          clear,
  output logic [7:0]    status,
  output logic          irq
);
  logic ovf_q;
  logic level;

  assign level = (count >= thr);

  // A drop in the clearing cycle wins so no event is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ovf_q <= 1'b0;
    else if (drop)  ovf_q <= 1'b1;
    else if (clear) ovf_q <= 1'b0;
  end

  always_comb begin
    status           = '0;
    status[ST_EMPTY] = empty;
    status[ST_LEVEL] = level;
    status[ST_FULL]  = full;
    status[ST_OVF]   = ovf_q;
  end

  assign irq = empty | level | full;
endmodule

// File: rtl/lblf_rx_top.sv
module lblf_rx_top
  import lblf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_wdata,
  input  logic              thr_we,
  input  logic [CW-1:0]     thr_wdata,
  input  logic              lbl_we,
  input  logic [LBL_W-1:0]  lbl_idx,
  input  logic [NSDI-1:0]   lbl_mask,
  input  logic              fifo_re,
  output logic [WORD_W-1:0] fifo_rdata,
  input  logic              stat_re,
  output logic [7:0]        stat_out,
  output logic              irq
);
  logic          cmp_en_q;
  logic [CW-1:0] thr_q;
  logic          reinit;
  logic          lookup_hit;
  logic          accept;
  logic          push_drop;
  logic          push_ok, pop_ok;
  logic          fifo_full, fifo_empty;
  logic [CW-1:0] fifo_count;
  logic          ctrl_unused;

  assign ctrl_unused = ^ctrl_wdata[6:1];
  assign reinit      = ctrl_we && ctrl_wdata[CTRL_REINIT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_en_q <= 1'b0;
      thr_q    <= CW'(DEPTH / 2);
    end else begin
      if (ctrl_we) cmp_en_q <= ctrl_wdata[CTRL_CMP_BIT];
      if (thr_we)  thr_q    <= thr_wdata;
    end
  end

  lblf_label_table u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .reinit   (reinit),
    .wr_en    (lbl_we),
    .wr_label (lbl_idx),
    .wr_mask  (lbl_mask),
    .rd_label (word_data[LBL_W-1:0]),
    .rd_sdi   (word_data[LBL_W +: SDI_W]),
    .hit      (lookup_hit)
  );

  assign accept    = word_valid && admit(cmp_en_q, lookup_hit);
  assign push_drop = accept && fifo_full;

  lblf_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (accept),
    .din     (word_data),
    .pop     (fifo_re),
    .dout    (fifo_rdata),
    .count   (fifo_count),
    .full    (fifo_full),
    .empty   (fifo_empty),
    .push_ok (push_ok),
    .pop_ok  (pop_ok)
  );

  lblf_status #(.CW(CW)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .empty  (fifo_empty),
    .full   (fifo_full),
    .count  (fifo_count),
    .thr    (thr_q),
    .drop   (push_drop),
    .clear  (stat_re),
    .status (stat_out),
    .irq    (irq)
  );
endmodule

// File: rtl/lblf_rx_chk.sv
module lblf_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        word_valid,
  input logic        cmp_en,
  input logic        lookup_hit,
  input logic        accept,
  input logic        fifo_full,
  input logic        fifo_empty,
  input logic        push_ok,
  input logic        pop_ok,
  input logic [31:0] fifo_rdata,
  input logic [7:0]  status,
  input logic        stat_re,
  input logic        irq,
  input logic        reinit,
  input logic        lbl_we
);
  // R1: with compare off, an offered word reaches a non-full FIFO.
  p_nocmp_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !cmp_en && !fifo_full |=> !fifo_empty);

  // R2: a rejected word cannot fill an empty FIFO.
  p_reject_no_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && cmp_en && !lookup_hit && fifo_empty |=> fifo_empty);

  // R3: a word passing the filter into a full FIFO raises overflow.
  p_drop_sets_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && fifo_full |=> status[3]);

  // R3: no write slips into a full FIFO.
  p_no_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !push_ok);

  // R4: overflow holds until a status read.
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] && !stat_re |=> status[3]);

  // R4: a status read without a fresh drop clears overflow.
  p_ovf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_re && !(accept && fifo_full) |=> !status[3]);

  // R5: right after invalidation with no table write, nothing hits.
  p_reinit_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reinit && !lbl_we |=> !lookup_hit);

  // R6: empty and full never coincide.
  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[0] && status[2]));

  // R7: interrupt follows the fill flags.
  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (status[0] | status[1] | status[2]));

  // R8: empty FIFO shows zero data and a read cannot pop.
  p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> (fifo_rdata == 32'd0) && !pop_ok);
endmodule

bind lblf_rx_top lblf_rx_chk u_lblf_rx_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_valid (word_valid),
  .cmp_en     (cmp_en_q),
  .lookup_hit (lookup_hit),
  .accept     (accept),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .push_ok    (push_ok),
  .pop_ok     (pop_ok),
  .fifo_rdata (fifo_rdata),
  .status     (stat_out),
  .stat_re    (stat_re),
  .irq        (irq),
  .reinit     (reinit),
  .lbl_we     (lbl_we)
);

// File: tb/test_lblf_rx_top.sv
`timescale 1ns/1ps
module test_lblf_rx_top;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          word_valid = 1'b0;
  logic [31:0]   word_data = '0;
  logic          ctrl_we = 1'b0;
  logic [7:0]    ctrl_wdata = '0;
  logic          thr_we = 1'b0;
  logic [CW-1:0] thr_wdata = '0;
  logic          lbl_we = 1'b0;
  logic [7:0]    lbl_idx = '0;
  logic [3:0]    lbl_mask = '0;
  logic          fifo_re = 1'b0;
  logic [31:0]   fifo_rdata;
  logic          stat_re = 1'b0;
  logic [7:0]    stat_out;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit tb_valid [256];
  logic [3:0] tb_mask [256];
  logic [31:0] held [DEPTH];

  always #2.5 clk = ~clk;

  lblf_rx_top #(.DEPTH(DEPTH)) i_lblf_rx_top (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .lbl_we(lbl_we), .lbl_idx(lbl_idx), .lbl_mask(lbl_mask), .fifo_re(fifo_re),
    .fifo_rdata(fifo_rdata), .stat_re(stat_re), .stat_out(stat_out), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic offer(input logic [31:0] w);
    word_valid = 1'b1; word_data = w;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic pop();
    fifo_re = 1'b1;
    @(negedge clk);
    fifo_re = 1'b0;
  endtask

  task automatic ctrl(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic set_thr(input int t);
    thr_we = 1'b1; thr_wdata = CW'(t);
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  task automatic load_label(input int l, input logic [3:0] m);
    lbl_we = 1'b1; lbl_idx = 8'(l); lbl_mask = m;
    @(negedge clk);
    lbl_we = 1'b0;
    tb_valid[l] = 1'b1; tb_mask[l] = m;
  endtask

  task automatic stat_read();
    stat_re = 1'b1;
    @(negedge clk);
    stat_re = 1'b0;
  endtask

  function automatic logic [31:0] mk_word(input int l, input int s, input int salt);
    return {22'(l * 37 + s * 11 + salt), 2'(s), 8'(l)};
  endfunction

  function automatic logic [7:0] exp_stat(input int cnt, input int thr, input bit ovf);
    return {4'b0, ovf, (cnt == DEPTH), (cnt >= thr), (cnt == 0)};
  endfunction

  // Offer every label with every source/destination code under compare-enable.
  task automatic sweep(input string req, input int salt);
    for (int l = 0; l < 256; l++) begin
      for (int s = 0; s < 4; s++) begin
        logic [31:0] w;
        bit hit;
        w = mk_word(l, s, salt);
        hit = tb_valid[l] && tb_mask[l][s];
        offer(w);
        if (hit) begin
          check(req, fifo_rdata, w);
          pop();
        end else begin
          check(req, {31'b0, stat_out[0]}, 32'd1);
        end
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin tb_valid[i] = 1'b0; tb_mask[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 / R6 / R7: reset state, threshold DEPTH/2.
    check("R10 status", {24'b0, stat_out}, {24'b0, exp_stat(0, DEPTH / 2, 0)});
    check("R7 irq", {31'b0, irq}, 32'd1);
    check("R8 empty data", fifo_rdata, 32'd0);

    // R8: read on empty changes nothing.
    pop();
    check("R8 empty after read", {24'b0, stat_out}, {24'b0, exp_stat(0, DEPTH / 2, 0)});

    // R1 / R10: compare disabled after reset, order kept.
    for (int k = 0; k < 3; k++) offer(mk_word(k * 85, k, 7));
    for (int k = 0; k < 3; k++) begin
      check("R1 R9 order", fifo_rdata, mk_word(k * 85, k, 7));
      pop();
    end
    check("R8 drained", fifo_rdata, 32'd0);

    // R10 / R2: compare on with an untouched table rejects everything.
    ctrl(8'h01);
    sweep("R10 R2 empty table", 1);

    // R2: program every third label with mask = low label bits.
    for (int l = 0; l < 256; l += 3) load_label(l, 4'(l));
    sweep("R2 filter", 2);

    // R5: invalidation (bit 7) keeps compare on (bit 0), nothing matches.
    ctrl(8'h81);
    for (int i = 0; i < 256; i++) tb_valid[i] = 1'b0;
    sweep("R5 after invalidate", 3);

    // R5: fresh entries match, stale ones stay dead.
    for (int l = 0; l < 256; l += 5) load_label(l, 4'hF);
    sweep("R5 new entries", 4);

    // R6 / R7: fill to full with compare off and threshold 3.
    ctrl(8'h00);
    set_thr(3);
    check("R6 thr empty", {24'b0, stat_out}, {24'b0, exp_stat(0, 3, 0)});
    for (int k = 0; k < DEPTH; k++) begin
      held[k] = mk_word(k + 16, k % 4, 9);
      offer(held[k]);
      check("R6 fill flags", {24'b0, stat_out}, {24'b0, exp_stat(k + 1, 3, 0)});
      check("R7 irq fill", {31'b0, irq}, {31'b0, (k + 1 >= 3)});
    end

    // R3: word into a full FIFO is dropped and flags overflow.
    offer(32'hDEAD_BEEF);
    check("R3 overflow", {24'b0, stat_out}, {24'b0, exp_stat(DEPTH, 3, 1)});

    // R4: sticky until read, visible during the read cycle.
    @(negedge clk);
    check("R4 sticky", {24'b0, stat_out}, {24'b0, exp_stat(DEPTH, 3, 1)});
    stat_read();
    check("R4 cleared", {24'b0, stat_out}, {24'b0, exp_stat(DEPTH, 3, 0)});

    // R3 / R9: contents unchanged by the drop.
    for (int k = 0; k < DEPTH; k++) begin
      check("R3 R9 drain", fifo_rdata, held[k]);
      pop();
      check("R6 drain flags", {24'b0, stat_out}, {24'b0, exp_stat(DEPTH - k - 1, 3, 0)});
    end

    // R6 / R7: threshold zero raises the level flag on an empty FIFO.
    set_thr(0);
    check("R6 thr zero", {24'b0, stat_out}, {24'b0, exp_stat(0, 0, 0)});
    check("R7 irq thr zero", {31'b0, irq}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule